// File: doc/BRIEF.md
# S/PDIF Consumer Audio Transmitter

This block turns stereo linear-PCM sample pairs into a consumer-format IEC 60958 line signal. Software loads a left and a right sample word, two status words and a control word through a simple write port. For every frame the block sends two 32-slot subframes, left then right. Each subframe carries a preamble, the audio bits, the validity and user bits, one channel-status bit and an even-parity bit. The whole stream is biphase-mark coded, and every half-bit is held for a fixed number of clock cycles.

At the start of each frame the block copies the sample pair and the per-channel flags into a working copy, and it raises a new-word request. Writing the left sample clears that request. If software misses a frame, the previous pair is sent again. One channel-status bit is sent per frame, the same bit in both subframes, selected by a frame counter that runs through the status block. The interrupt output is the request gated by an enable bit, while the request output itself is never gated.

Top module: `spdif_tx`

## Requirements
- R1: After reset, spdif_o is low, req_o is high, irq_o is low, the transmitter is disabled, and every status, user and validity field is zero.
- R2: While the enable bit (control bit 12) is clear, spdif_o stays low, and the frame and bit position return to the start. After enable is set, the first half-bit of frame 0 appears one cycle after the enabling write takes effect.
- R3: The request flag is set at each frame start, which is the cycle the sample pair is captured. A write to address 0 (left sample) clears it. If a left write lands on the same edge as a capture, the flag stays clear.
- R4: irq_o is high exactly when the request flag is high and the interrupt-enable bit (control bit 13) is set. req_o does not depend on control bit 13.
- R5: Each half-bit lasts DIV clock cycles. A subframe is 64 half-bits. A frame is the left subframe followed by the right subframe.
- R6: Slots 0–3 carry an 8-half-bit preamble, given here for a line that was low before it: 11101000 on the left subframe of frame 0, 11100010 on every other left subframe, and 11100100 on every right subframe. Each pattern is inverted when the line was high.
- R7: Slots 4–27 carry the 24-bit audio word, LSB first. A SAMPLE_W-bit sample (address 0 left, address 1 right) is left-justified, with zeros padded below it. The pair is captured at frame start, and it is repeated if software has not rewritten it.
- R8: Slot 28 carries validity and slot 29 carries user data. For the left subframe they come from control bits 8 and 9; for the right subframe they come from bits 10 and 11. They are captured at frame start.
- R9: Slot 30 carries channel-status bit n in both subframes of frame n. Bits 15:0 come from address 2 bits 15:0. Bits 29:16 come from address 3 bits 13:0, and bits 31:30 are always 0. Bits 39:32 come from control bits 7:0. Higher bits are 0. The frame counter wraps after FRAMES frames.
- R10: Slot 31 is even parity over slots 4–30. Each data slot has a line transition at its start and a second one at mid-slot when the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 left, 1 right, 2 status low, 3 status mid, 4 control |
| wr_data | input | max(SAMPLE_W,16) | Register write data |
| spdif_o | output | 1 | Biphase-mark coded line output |
| req_o | output | 1 | New-sample-pair request flag |
| irq_o | output | 1 | Request gated by interrupt enable |

## Verification
The bench builds the block with SAMPLE_W=20, DIV=2 and FRAMES=48. With 20-bit samples, the four zero pad bits below the sample are visible. With two cycles per half-bit, the hold-between-updates behaviour is exercised. A 48-frame block lets the counter wrap and the block-start preamble come back within about 12,000 cycles. It still reaches every mapped status bit and the zero bits beyond bit 39. Every cycle is compared against a behavioural model that rebuilds each frame's half-bit levels, across refilled, repeated and partly refilled sample pairs, a left write that coincides with a frame start, a masked-interrupt interval, and a mid-frame disable.

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int SAMPLE_W = 24,
  parameter int DIV      = 4,
  parameter int FRAMES   = 192
)(
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [2:0]                                    wr_addr,
  input  logic [((SAMPLE_W > 16) ? SAMPLE_W : 16)-1:0]  wr_data,
  output logic                                          spdif_o,
  output logic                                          req_o,
  output logic                                          irq_o
);
  localparam int PAD = 24 - SAMPLE_W;
  localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FW  = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [FW-1:0] FR_LAST  = FW'(FRAMES - 1);

  logic [SAMPLE_W-1:0] smp_l, smp_r, sh_l, sh_r;
  logic [15:0]         st_lo, st_mid;
  logic [13:0]         ctrl;
  logic [3:0]          sh_flags;
  logic                sh_cs, req, line, pol;
  logic [DW-1:0]       div_cnt;
  logic [6:0]          half;
  logic [FW-1:0]       frame_cnt;

  logic en, ie, tick, step, sub, frame_start, wr_left;
  logic [4:0] slot;
  assign en          = ctrl[12];
  assign ie          = ctrl[13];
  assign tick        = en && (div_cnt == '0);
  assign step        = en && (div_cnt == DIV_LAST);
  assign sub         = half[6];
  assign slot        = half[5:1];
  assign frame_start = tick && (half == 7'd0);
  assign wr_left     = wr_en && (wr_addr == 3'd0);

  // channel-status bit for the current frame
  logic [39:0] cs_vec;
  int unsigned fidx;
  logic        cs_now;
  assign cs_vec = {ctrl[7:0], 2'b00, st_mid[13:0], st_lo};
  assign fidx   = 32'(frame_cnt);
  assign cs_now = (fidx < 32'd40) ? cs_vec[fidx[5:0]] : 1'b0;

  // payload of the subframe in flight
  logic [23:0] aud;
  logic [4:0]  aidx;
  logic        vbit, ubit, par, data_bit;
  assign aud  = (sub ? 24'(sh_r) : 24'(sh_l)) << PAD;
  assign vbit = sub ? sh_flags[2] : sh_flags[0];
  assign ubit = sub ? sh_flags[3] : sh_flags[1];
  assign par  = ^{aud, vbit, ubit, sh_cs};
  assign aidx = slot - 5'd4;

  always_comb begin
    if (slot < 5'd28)       data_bit = aud[aidx];
    else if (slot == 5'd28) data_bit = vbit;
    else if (slot == 5'd29) data_bit = ubit;
    else if (slot == 5'd30) data_bit = sh_cs;
    else                    data_bit = par;
  end

  // next line level
  logic [7:0] pat;
  logic [2:0] pidx;
  logic       pol_now, nxt;
  assign pat     = sub ? 8'b11100100 : ((frame_cnt == '0) ? 8'b11101000 : 8'b11100010);
  assign pidx    = 3'd7 - half[2:0];
  assign pol_now = (half[5:0] == 6'd0) ? line : pol;

  always_comb begin
    if (slot < 5'd4)   nxt = pat[pidx] ^ pol_now;
    else if (!half[0]) nxt = ~line;
    else               nxt = line ^ data_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_l  <= '0;
      smp_r  <= '0;
      st_lo  <= '0;
      st_mid <= '0;
      ctrl   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0:    smp_l  <= wr_data[SAMPLE_W-1:0];
        3'd1:    smp_r  <= wr_data[SAMPLE_W-1:0];
        3'd2:    st_lo  <= wr_data[15:0];
        3'd3:    st_mid <= wr_data[15:0];
        3'd4:    ctrl   <= wr_data[13:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           req <= 1'b1;
    else if (wr_left)     req <= 1'b0;
    else if (frame_start) req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l     <= '0;
      sh_r     <= '0;
      sh_flags <= '0;
      sh_cs    <= 1'b0;
    end else if (frame_start) begin
      sh_l     <= smp_l;
      sh_r     <= smp_r;
      sh_flags <= ctrl[11:8];
      sh_cs    <= cs_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      half      <= '0;
      frame_cnt <= '0;
      line      <= 1'b0;
      pol       <= 1'b0;
    end else if (!en) begin
      div_cnt   <= '0;
      half      <= '0;
      frame_cnt <= '0;
      line      <= 1'b0;
      pol       <= 1'b0;
    end else begin
      if (tick) begin
        line <= nxt;
        if (half[5:0] == 6'd0) pol <= line;
      end
      if (step) begin
        div_cnt <= '0;
        half    <= half + 7'd1;
        if (half == 7'd127)
          frame_cnt <= (frame_cnt == FR_LAST) ? '0 : frame_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign spdif_o = line;
  assign req_o   = req;
  assign irq_o   = req & ie;
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int DIV    = 4,
  parameter int FRAMES = 192
)(
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          wr_en,
  input logic [2:0]                                    wr_addr,
  input logic                                          spdif_o,
  input logic                                          req_o,
  input logic                                          irq_o,
  input logic                                          en,
  input logic                                          ie,
  input logic [((DIV > 1) ? $clog2(DIV) : 1)-1:0]      div_cnt,
  input logic [6:0]                                    half,
  input logic [((FRAMES > 1) ? $clog2(FRAMES) : 1)-1:0] frame_cnt
);
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [FW-1:0] FR_LAST = FW'(FRAMES - 1);

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !spdif_o);

  p_left_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> !req_o);

  p_frame_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_cnt == '0 && half == 7'd0 && !(wr_en && wr_addr == 3'd0)) |=> req_o);

  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_o && ie));

  p_half_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_cnt != '0) |=> $stable(spdif_o));

  p_slot_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_cnt == '0 && !half[0] && half[5:1] >= 5'd4) |=> (spdif_o != $past(spdif_o)));

  p_frame_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= FR_LAST);
endmodule

bind spdif_tx spdif_tx_chk #(.DIV(DIV), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .spdif_o(spdif_o), .req_o(req_o), .irq_o(irq_o), .en(en), .ie(ie),
  .div_cnt(div_cnt), .half(half), .frame_cnt(frame_cnt)
);

// File: tb/tb_spdif_tx.sv
module tb_spdif_tx;
  localparam int SAMPLE_W = 20;
  localparam int DIV      = 2;
  localparam int FRAMES   = 48;
  localparam int WD       = 20;
  localparam int FRAME_CYC = 128 * DIV;
  localparam int EN_BIT = 1 << 12;
  localparam int IE_BIT = 1 << 13;
  localparam int CS_HI  = 'h9D;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [WD-1:0] wr_data = '0;
  logic spdif_o, req_o, irq_o;

  always #4 clk = ~clk;

  spdif_tx #(.SAMPLE_W(SAMPLE_W), .DIV(DIV), .FRAMES(FRAMES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .spdif_o(spdif_o), .req_o(req_o), .irq_o(irq_o));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit chk_on = 0, done = 0;

  // behavioural reference state
  int m_l = 0, m_r = 0, m_st0 = 0, m_st1 = 0, m_ctrl = 0;
  int m_div = 0, m_half = 0, m_frame = 0;
  bit m_line = 0, m_req = 1, m_irq = 0;
  string m_tag = "R1 reset";
  bit lv[128];
  string tg[128];

  function automatic bit cs_of(int f);
    if (f < 16) return bit'((m_st0 >> f) & 1);
    if (f < 30) return bit'((m_st1 >> (f - 16)) & 1);
    if (f < 32) return 1'b0;
    if (f < 40) return bit'((m_ctrl >> (f - 32)) & 1);
    return 1'b0;
  endfunction

  function automatic void build_frame();
    bit cur, pol, p;
    bit b[32];
    int smp, pat, base;
    cur = m_line;
    for (int s = 0; s < 2; s++) begin
      smp  = (s == 1) ? m_r : m_l;
      pat  = (s == 1) ? 'hE4 : ((m_frame == 0) ? 'hE8 : 'hE2);
      base = s * 64;
      for (int k = 0; k < 24; k++) b[4 + k] = bit'(((smp << (24 - SAMPLE_W)) >> k) & 1);
      b[28] = bit'((m_ctrl >> (s == 1 ? 10 : 8)) & 1);
      b[29] = bit'((m_ctrl >> (s == 1 ? 11 : 9)) & 1);
      b[30] = cs_of(m_frame);
      p = 0;
      for (int k = 4; k < 31; k++) p ^= b[k];
      b[31] = p;
      pol = cur;
      for (int i = 0; i < 8; i++) begin
        cur = bit'((pat >> (7 - i)) & 1) ^ pol;
        lv[base + i] = cur;
        tg[base + i] = "R5 R6 preamble";
      end
      for (int sl = 4; sl < 32; sl++) begin
        string t;
        if (sl < 28) t = "R7 R10 audio";
        else if (sl < 30) t = "R8 R10 validity/user";
        else if (sl == 30) t = "R9 R10 status";
        else t = "R10 parity";
        cur = ~cur;
        lv[base + 2*sl] = cur;
        tg[base + 2*sl] = t;
        cur = cur ^ b[sl];
        lv[base + 2*sl + 1] = cur;
        tg[base + 2*sl + 1] = t;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_l = 0; m_r = 0; m_st0 = 0; m_st1 = 0; m_ctrl = 0;
      m_div = 0; m_half = 0; m_frame = 0;
      m_line = 0; m_req = 1; m_irq = 0; m_tag = "R1 reset";
    end else begin
      if (((m_ctrl >> 12) & 1) != 0) begin
        if (m_div == 0) begin
          if (m_half == 0) begin
            build_frame();
            m_req = 1;
          end
          m_line = lv[m_half];
          m_tag  = tg[m_half];
        end
        if (m_div == DIV - 1) begin
          m_div  = 0;
          m_half = (m_half + 1) % 128;
          if (m_half == 0) m_frame = (m_frame + 1) % FRAMES;
        end else begin
          m_div++;
        end
      end else begin
        m_div = 0; m_half = 0; m_frame = 0; m_line = 0; m_tag = "R2 idle";
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_l = int'(wr_data); m_req = 0; end
          3'd1: m_r = int'(wr_data);
          3'd2: m_st0 = int'(wr_data[15:0]);
          3'd3: m_st1 = int'(wr_data[15:0]);
          3'd4: m_ctrl = int'(wr_data[13:0]);
          default: ;
        endcase
      end
      m_irq = m_req && (((m_ctrl >> 13) & 1) != 0);
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(spdif_o, m_line, m_tag);
      check(req_o, m_req, "R3 request flag");
      check(irq_o, m_irq, "R4 interrupt");
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R5 watchdog: actual cycles=%0d expected below %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = WD'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  int ctrl_v;

  initial begin
    @(posedge clk);
    chk_on = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spdif_o, 1'b0, "R1 line after reset");
    check(req_o, 1'b1, "R1 request after reset");
    check(irq_o, 1'b0, "R1 irq after reset");

    wr(2, 'hA5C3);
    wr(3, 'hF1B6);
    ctrl_v = CS_HI | (1 << 8) | (1 << 11);
    wr(4, ctrl_v);
    repeat (20) @(negedge clk);            // R2: still idle
    wr(1, 'h5A5A5);
    wr(0, 'h12345);
    ctrl_v = ctrl_v | EN_BIT | IE_BIT;
    wr(4, ctrl_v);
    while (!req_o) @(negedge clk);

    for (int f = 0; f < 56; f++) begin
      int used;
      used = 0;
      if (f == 40) begin
        // R3: left write landing on a frame-start edge
        repeat (FRAME_CYC - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = WD'('h0F0F0);
        @(negedge clk);
        wr_en = 1'b0;
        check(req_o, 1'b0, "R3 left write on capture edge");
      end else begin
        if (f == 20) begin ctrl_v = ctrl_v & ~IE_BIT; wr(4, ctrl_v); used += 2; end
        if (f == 30) begin ctrl_v = ctrl_v | IE_BIT;  wr(4, ctrl_v); used += 2; end
        case (f % 5)
          0: begin
            ctrl_v = (ctrl_v & ~('hF << 8)) | ((f & 15) << 8);
            wr(4, ctrl_v);
            wr(1, (f * 'h2F1D + 'h777) & 'hFFFFF);
            wr(0, (f * 'h1357B + 'h2468) & 'hFFFFF);
            used += 6;
          end
          1: begin
            wr(1, (f * 'h3C3C1) & 'hFFFFF);
            wr(0, ~(f * 'h111) & 'hFFFFF);
            used += 4;
          end
          2: ;
          3: begin
            wr(0, (f * 'h0ABCD) & 'hFFFFF);
            used += 2;
          end
          default: begin
            wr(1, 'h00000);
            wr(0, 'hFFFFF);
            used += 4;
          end
        endcase
        repeat (FRAME_CYC - used) @(negedge clk);
      end
    end

    repeat (100) @(negedge clk);
    wr(4, ctrl_v & ~EN_BIT);               // R2: mid-frame disable
    repeat (50) @(negedge clk);
    wr(0, 'h81818);
    wr(4, ctrl_v);
    repeat (3 * FRAME_CYC) @(negedge clk);
    finish_run();
  end
endmodule